// File: doc/BRIEF.md
# Double to Single Store Converter

This block turns a 64-bit double-format register image into the 32-bit single-format word that a single-precision store writes to memory. It does not round. Each input falls into one of three conversion classes, and the class picks how the output bits are formed:

- **CLS_PASS** selects bits mechanically. It covers zero, normal values, infinities, NaNs and values too large for single format.
- **CLS_SUBN** shifts the significand right by hand when the value lies in the single subnormal range.
- **CLS_FLUSH** outputs a signed zero for magnitudes below the smallest single subnormal.

The class decision is purely combinational. The chosen word and a valid strobe leave through one register stage. The class for each input is fixed by that input alone:

- CLS_PASS is taken when the magnitude is zero or the biased double exponent is above 896.
- CLS_SUBN is taken when the biased exponent is between 874 and 896.
- CLS_FLUSH is taken otherwise.

No state carries over from one input to the next.

A store pipeline drives `in_word` with `in_valid` high. It then takes `out_word` one clock later, when `out_valid` is high.

Top module: `dbl_to_sgl_store`

## Requirements
- R1: Output bit 31 equals input bit 63 for every accepted input.
- R2: When the biased input exponent (bits 62..52) exceeds 896, the output is formed as follows: bit 30 is input bit 62, bits 29..23 are input bits 58..52, and bits 22..0 are input bits 51..29.
- R3: An input whose bits 62..0 are all zero gives a zero output with the input's sign.
- R4: Infinities, NaNs and finite values above the single maximum use the R2 bit copy unchanged, without saturation.
- R5: When the biased exponent is between 874 and 896 inclusive, output bits 30..23 are zero. Output bits 22..0 are the 24-bit value {1, input bits 51..29} shifted right by (897 - biased exponent), a shift of 1 to 23.
- R6: A nonzero magnitude with a biased exponent below 874 gives the sign bit followed by 31 zero bits.
- R7: Input bits 28..0 never affect the output, so fractions are truncated.
- R8: `out_valid` equals `in_valid` one clock later. Synchronous reset clears `out_valid` and `out_word` to zero.
- R9: While `in_valid` is low, `out_word` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word strobe |
| in_word | input | 64 | Double-format register image |
| out_valid | output | 1 | Output word strobe, one cycle after `in_valid` |
| out_word | output | 32 | Single-format memory word |

## Verification
The hardest region to reach is the narrow band of 23 biased exponents, 874 to 896, where CLS_SUBN applies. Its two edges matter most:

- At exponent 896 the shift is one place.
- At exponent 874 only the implicit one survives, in bit 0.
- Exponent 873 must flush.

Uniform random 64-bit words almost never land in this band. The stimulus therefore overwrites the exponent field of most random words with a value drawn from 860 to 910, and adds directed words at each boundary exponent.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    // Default field widths of the two formats
    localparam int DBL_EXP_W  = 11;
    localparam int DBL_FRAC_W = 52;
    localparam int SGL_EXP_W  = 8;
    localparam int SGL_FRAC_W = 23;

    // Conversion class chosen per input word
    typedef enum logic [1:0] {
        CLS_PASS  = 2'd0,
        CLS_SUBN  = 2'd1,
        CLS_FLUSH = 2'd2
    } cls_e;

endpackage

// File: rtl/dsc_classify.sv
module dsc_classify
    import dsc_pkg::*;
#(
    parameter int DEW = DBL_EXP_W,
    parameter int DFW = DBL_FRAC_W,
    parameter int SEW = SGL_EXP_W,
    parameter int SFW = SGL_FRAC_W,
    parameter int SH_W = $clog2(SFW + 1)
) (
    input  logic [DEW-1:0]  exp_fld,
    input  logic [DFW-1:0]  frac_fld,
    output cls_e            cls,
    output logic [SH_W-1:0] shamt
);
    localparam int DBL_BIAS = (1 << (DEW - 1)) - 1;
    localparam int SGL_BIAS = (1 << (SEW - 1)) - 1;
    // biased exponent above this keeps the mechanical copy
    localparam logic [DEW-1:0] PASS_ABOVE = DEW'(DBL_BIAS - SGL_BIAS);
    // shift base: shift = SUBN_BASE - biased exponent
    localparam logic [DEW-1:0] SUBN_BASE  = DEW'(DBL_BIAS - SGL_BIAS + 1);
    // lowest biased exponent still representable as a single subnormal
    localparam logic [DEW-1:0] SUBN_LO    = DEW'(DBL_BIAS - SGL_BIAS + 1 - SFW);

    logic            mag_zero;
    logic [DEW-1:0]  diff;

    assign mag_zero = (exp_fld == '0) && (frac_fld == '0);
    assign diff     = SUBN_BASE - exp_fld;
    assign shamt    = diff[SH_W-1:0];

    always_comb begin
        if (mag_zero || (exp_fld > PASS_ABOVE)) begin
            cls = CLS_PASS;
        end else if (exp_fld >= SUBN_LO) begin
            cls = CLS_SUBN;
        end else begin
            cls = CLS_FLUSH;
        end
    end

endmodule

// File: rtl/dsc_subn_shift.sv
module dsc_subn_shift #(
    parameter int SFW  = 23,
    parameter int SH_W = $clog2(SFW + 1)
) (
    input  logic [SFW-1:0]  frac_hi,
    input  logic [SH_W-1:0] shamt,
    output logic [SFW-1:0]  subn_frac
);
    // stage 0 holds the significand with its implicit leading one
    logic [SFW:0] stage [0:SH_W];

    assign stage[0] = {1'b1, frac_hi};

    for (genvar g = 0; g < SH_W; g++) begin : g_stage
        assign stage[g+1] = shamt[g] ? (stage[g] >> (1 << g)) : stage[g];
    end

    assign subn_frac = stage[SH_W][SFW-1:0];

endmodule

// File: rtl/dbl_to_sgl_store.sv
module dbl_to_sgl_store
    import dsc_pkg::*;
#(
    parameter int DEW = DBL_EXP_W,
    parameter int DFW = DBL_FRAC_W,
    parameter int SEW = SGL_EXP_W,
    parameter int SFW = SGL_FRAC_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [DEW+DFW:0]       in_word,
    output logic                   out_valid,
    output logic [SEW+SFW:0]       out_word
);
    localparam int DW   = 1 + DEW + DFW;
    localparam int SW   = 1 + SEW + SFW;
    localparam int SH_W = $clog2(SFW + 1);

    logic            sgn;
    logic [DEW-1:0]  exp_fld;
    logic [DFW-1:0]  frac_fld;
    logic [SFW-1:0]  frac_hi;
    cls_e            cls;
    logic [SH_W-1:0] shamt;
    logic [SFW-1:0]  subn_frac;
    logic [SW-1:0]   next_word;

    assign sgn      = in_word[DW-1];
    assign exp_fld  = in_word[DW-2 -: DEW];
    assign frac_fld = in_word[DFW-1:0];
    assign frac_hi  = frac_fld[DFW-1 -: SFW];

    dsc_classify #(.DEW(DEW), .DFW(DFW), .SEW(SEW), .SFW(SFW), .SH_W(SH_W)) u_cls (
        .exp_fld  (exp_fld),
        .frac_fld (frac_fld),
        .cls      (cls),
        .shamt    (shamt)
    );

    dsc_subn_shift #(.SFW(SFW), .SH_W(SH_W)) u_shift (
        .frac_hi   (frac_hi),
        .shamt     (shamt),
        .subn_frac (subn_frac)
    );

    // output word selected by conversion class
    always_comb begin
        unique case (cls)
            CLS_PASS:  next_word = {sgn, exp_fld[DEW-1], exp_fld[SEW-2:0], frac_hi};
            CLS_SUBN:  next_word = {sgn, {SEW{1'b0}}, subn_frac};
            CLS_FLUSH: next_word = {sgn, {(SW-1){1'b0}}};
            default:   next_word = {sgn, {(SW-1){1'b0}}};
        endcase
    end

    // output register stage
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_word <= next_word;
            end
        end
    end

    assert_valid_delay_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_valid_drop_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_sign_copy_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_word[SW-1] == $past(in_word[DW-1])));
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_word));
    assert_flush_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cls == CLS_FLUSH) |=> (out_word[SW-2:0] == '0));
    assert_subn_shape_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cls == CLS_SUBN) |=>
            (out_word[SW-2 -: SEW] == '0) && (out_word[SFW-1:0] != '0));
    assert_shift_range_R5: assert property (@(posedge clk) disable iff (rst)
        (cls == CLS_SUBN) |-> (shamt >= SH_W'(1)) && (shamt <= SH_W'(SFW)));

endmodule

// File: tb/dbl_to_sgl_store_bench.sv
`timescale 1ns/1ps
module dbl_to_sgl_store_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] in_word = '0;
    logic        out_valid;
    logic [31:0] out_word;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dbl_to_sgl_store u_dbl_to_sgl_store (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .out_valid (out_valid),
        .out_word  (out_word)
    );

    function automatic logic [31:0] model(input logic [63:0] d);
        int e;
        int unb;
        int sh;
        logic [23:0] m;
        e   = int'(d[62:52]);
        unb = e - 1023;
        if (unb > -127 || d[62:0] == '0) begin
            return {d[63], d[62], d[58:52], d[51:29]};
        end else if (unb >= -149) begin
            sh = -126 - unb;
            m  = {1'b1, d[51:29]} >> sh;
            return {d[63], 8'h00, m[22:0]};
        end
        return {d[63], 31'b0};
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %08h expected %08h", tag, got, exp);
        end
    endtask

    // drive one word, sample after the register stage
    task automatic send(input string tag, input logic [63:0] d);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = d;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " valid R8"}, {31'b0, out_valid}, 32'd1);
        check(tag, out_word, model(d));
    endtask

    initial begin
        logic [31:0] held;
        logic [31:0] first;
        logic [63:0] d;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R8 reset out_word", out_word, 32'd0);
        check("R8 reset out_valid", {31'b0, out_valid}, 32'd0);
        rst = 1'b0;

        send("R3 positive zero", 64'h0000_0000_0000_0000);
        check("R3 positive zero value", out_word, 32'h0000_0000);
        send("R3 negative zero", 64'h8000_0000_0000_0000);
        check("R1 R3 negative zero value", out_word, 32'h8000_0000);
        send("R2 one", 64'h3FF0_0000_0000_0000);
        check("R2 one value", out_word, 32'h3F80_0000);
        send("R4 infinity", 64'h7FF0_0000_0000_0000);
        check("R4 infinity value", out_word, 32'h7F80_0000);
        send("R4 quiet nan", 64'hFFF8_0000_0000_0000);
        check("R4 quiet nan value", out_word, 32'hFFC0_0000);
        send("R4 large finite", 64'h4810_0000_2000_0000);
        check("R4 large finite value", out_word, 32'h4080_0001);
        send("R2 exp 897", 64'h3810_0000_0000_0000);
        check("R2 exp 897 value", out_word, 32'h0080_0000);
        send("R5 exp -127", 64'h3800_0000_0000_0000);
        check("R5 exp -127 value", out_word, 32'h0040_0000);
        send("R5 exp -149", 64'hB6AF_FFFF_FFFF_FFFF);
        check("R5 exp -149 value", out_word, 32'h8000_0001);
        send("R6 exp -150", 64'h369F_FFFF_FFFF_FFFF);
        check("R6 exp -150 value", out_word, 32'h0000_0000);
        send("R6 double subnormal", 64'h8000_0000_0000_0001);
        check("R6 double subnormal value", out_word, 32'h8000_0000);

        // R7: low fraction bits do not change the result
        send("R7 low bits clear", 64'h4009_21FB_4000_0000);
        first = out_word;
        send("R7 low bits set", 64'h4009_21FB_5FFF_FFFF);
        check("R7 truncation", out_word, first);

        // R9: output holds while in_valid is low
        held = out_word;
        @(negedge clk);
        in_word = 64'h1234_5678_9ABC_DEF0;
        @(negedge clk);
        check("R9 hold", out_word, held);
        check("R8 valid low", {31'b0, out_valid}, 32'd0);

        for (int i = 0; i < 400; i++) begin
            d = {$urandom(), $urandom()};
            if (($urandom() % 4) != 0) begin
                d[62:52] = 11'($urandom_range(910, 860));
            end
            send("R1 R2 R5 R6 random", d);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R8 actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule